// File: doc/BRIEF.md
# Serial Canonical Signed-Digit Recoder

This block turns an unsigned binary operand into its canonical signed-digit form, one digit per accepted transfer, starting from the least significant end. Each digit is −1, 0 or +1. The result has no two adjacent non-zero digits, and no other signed-digit form of the same value has fewer non-zero digits. A single carry flag and a two-bit window over the operand decide each digit, and the operand is treated as if two zero bits sat above its top bit. A WIDTH-bit operand therefore produces WIDTH+1 digits.

Software-free control is plain. A load pulse captures the operand and a start pulse begins a recoding run. A done flag rises once the final digit has been taken. The digit stream leaves through a valid/ready port. A digit is transferred on a clock edge where valid and ready are both high. While ready is low, the offered digit and its flags stay frozen and valid stays high. A consumer such as an add/subtract datapath uses the skip flag to step over zero digits.

Top module: `csd_recoder`

## Requirements
- R1: After reset, dig_valid_o, busy_o and done_o are all low.
- R2: A load pulse while idle captures operand_i. Load and start in the same idle cycle recode the new operand. A load pulse while busy has no effect on the running stream or on the operand used by later starts.
- R3: A start pulse while idle makes busy_o and dig_valid_o high on the following cycle, with digit 0 (least significant) offered. A start pulse while busy is ignored.
- R4: Digit encoding is dig_nz_o=1 for a non-zero digit, dig_neg_o=1 for −1 (dig_neg_o is 0 whenever dig_nz_o is 0). Digit i has weight 2^i, and the weighted sum of the digits equals the operand. The carry is clear after the last digit.
- R5: No two consecutively transferred digits of one run are both non-zero, so the digit string is the canonical form of the operand.
- R6: Exactly WIDTH+1 digits are transferred per run, and dig_last_o is high only on the final one. After that transfer, busy_o and dig_valid_o drop and done_o rises. done_o stays high until the next accepted load or start.
- R7: While dig_valid_o is high and dig_ready_i is low, dig_valid_o stays high and dig_neg_o, dig_nz_o and dig_last_o hold their values into the next cycle.
- R8: dig_skip_o is high exactly when the offered digit is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture operand_i when idle |
| operand_i | input | WIDTH | Binary operand to recode |
| start_i | input | 1 | Begin a recoding run when idle |
| dig_valid_o | output | 1 | A digit is offered |
| dig_ready_i | input | 1 | Consumer accepts the offered digit |
| dig_neg_o | output | 1 | Offered digit is −1 |
| dig_nz_o | output | 1 | Offered digit is non-zero |
| dig_skip_o | output | 1 | Offered digit is zero (no add/subtract needed) |
| dig_last_o | output | 1 | Offered digit is the most significant one |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run completed |

## Verification
On every cycle, the embedded assertions check several properties:
- the frozen digit under back-pressure;
- the absence of adjacent non-zero digits within a run;
- the clear carry on the final digit;
- the handover from the final transfer to done;
- the one-cycle entry into the busy state after an idle start.

Only the bench scenarios can show that the digit values are the canonical form of each operand and that their weighted sum restores the operand. The same applies to the rule that a load or start arriving mid-run leaves both the stream and later runs untouched. The bench compares every transfer against a behavioural reference under both a steady and an irregular ready pattern.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef struct packed {
    logic neg;
    logic nz;
  } csd_digit_t;
endpackage

// File: rtl/csd_digit_cell.sv
module csd_digit_cell
  import csd_pkg::*;
(
  input  logic       q_lo,
  input  logic       q_hi,
  input  logic       carry_in,
  output csd_digit_t digit,
  output logic       carry_out
);
  logic odd_sum;
  logic full_sum;

  always_comb begin
    odd_sum   = q_lo ^ carry_in;
    full_sum  = q_lo & carry_in;
    digit.nz  = odd_sum;
    digit.neg = odd_sum & q_hi;
    carry_out = full_sum | (odd_sum & q_hi);
  end
endmodule

// File: rtl/csd_operand_path.sv
module csd_operand_path #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             launch,
  input  logic             advance,
  input  logic [WIDTH-1:0] operand,
  output logic             q_lo,
  output logic             q_hi
);
  localparam int WORK_W = WIDTH + 2;

  logic [WIDTH-1:0]  held_q;
  logic [WORK_W-1:0] work_q;
  logic [WIDTH-1:0]  launch_val;

  always_comb launch_val = capture ? operand : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      work_q <= '0;
    end else begin
      if (capture) held_q <= operand;
      if (launch)       work_q <= {2'b00, launch_val};
      else if (advance) work_q <= work_q >> 1;
    end
  end

  always_comb begin
    q_lo = work_q[0];
    q_hi = work_q[1];
  end
endmodule

// File: rtl/csd_sequencer.sv
module csd_sequencer #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic start,
  input  logic xfer,
  output logic capture,
  output logic launch,
  output logic busy,
  output logic done,
  output logic last
);
  localparam int NDIG  = WIDTH + 1;
  localparam int CNT_W = $clog2(NDIG + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NDIG - 1);

  logic [CNT_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;

  always_comb begin
    capture = load & ~busy_q;
    launch  = start & ~busy_q;
    last    = busy_q & (idx_q == LAST_IDX);
    busy    = busy_q;
    done    = done_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (launch) begin
        idx_q  <= '0;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (xfer) begin
        idx_q <= idx_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (capture) begin
        done_q <= 1'b0;
      end
    end
  end

  p_start_enters_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && idx_q == '0));

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> (done && !busy));

  p_busy_ignores_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !xfer) |=> (busy && $stable(idx_q)));
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             start_i,
  output logic             dig_valid_o,
  input  logic             dig_ready_i,
  output logic             dig_neg_o,
  output logic             dig_nz_o,
  output logic             dig_skip_o,
  output logic             dig_last_o,
  output logic             busy_o,
  output logic             done_o
);
  logic       capture, launch, busy, done, last, xfer;
  logic       q_lo, q_hi;
  logic       carry_q, carry_nxt;
  csd_digit_t digit;

  csd_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load_i), .start(start_i), .xfer(xfer),
    .capture(capture), .launch(launch), .busy(busy), .done(done), .last(last)
  );

  csd_operand_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rst_n(rst_n), .capture(capture), .launch(launch),
    .advance(xfer), .operand(operand_i), .q_lo(q_lo), .q_hi(q_hi)
  );

  csd_digit_cell u_cell (
    .q_lo(q_lo), .q_hi(q_hi), .carry_in(carry_q),
    .digit(digit), .carry_out(carry_nxt)
  );

  always_comb begin
    xfer        = busy & dig_ready_i;
    dig_valid_o = busy;
    dig_neg_o   = busy & digit.neg;
    dig_nz_o    = busy & digit.nz;
    dig_skip_o  = busy & ~digit.nz;
    dig_last_o  = last;
    busy_o      = busy;
    done_o      = done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      carry_q <= 1'b0;
    else if (launch) carry_q <= 1'b0;
    else if (xfer)   carry_q <= carry_nxt;
  end

  logic prev_nz_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      prev_nz_q <= 1'b0;
    else if (launch) prev_nz_q <= 1'b0;
    else if (xfer)   prev_nz_q <= dig_nz_o;
  end

  p_no_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && prev_nz_q) |-> !dig_nz_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid_o && !dig_ready_i) |=>
      (dig_valid_o && $stable(dig_neg_o) && $stable(dig_nz_o) && $stable(dig_last_o)));

  p_carry_clear_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && dig_last_o) |-> !carry_nxt);

  p_neg_implies_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dig_neg_o |-> dig_nz_o);
endmodule

// File: tb/csd_recoder_bench.sv
module csd_recoder_bench;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_i = 1'b0;
  logic [WIDTH-1:0] operand_i = '0;
  logic             start_i = 1'b0;
  logic             dig_ready_i = 1'b0;
  logic dig_valid_o, dig_neg_o, dig_nz_o, dig_skip_o, dig_last_o, busy_o, done_o;

  int tests = 0;
  int fails = 0;
  int exp_q[$];
  int cnt;
  longint sum;
  int prev_d;
  logic stalled;
  logic [2:0] stall_snap;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  csd_recoder #(.WIDTH(WIDTH)) u_csd_recoder (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .operand_i(operand_i),
    .start_i(start_i), .dig_valid_o(dig_valid_o), .dig_ready_i(dig_ready_i),
    .dig_neg_o(dig_neg_o), .dig_nz_o(dig_nz_o), .dig_skip_o(dig_skip_o),
    .dig_last_o(dig_last_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: canonical form by odd-residue rule
  task automatic build_ref(input longint v);
    longint x = v;
    exp_q.delete();
    for (int i = 0; i <= WIDTH; i++) begin
      int d = 0;
      if (x % 2 != 0) d = (x % 4 == 1) ? 1 : -1;
      x = (x - d) / 2;
      exp_q.push_back(d);
    end
  endtask

  task automatic cyc(input logic rdy, input logic ld, input logic st,
                     input logic [WIDTH-1:0] val);
    int d;
    @(negedge clk);
    dig_ready_i = rdy; load_i = ld; start_i = st; operand_i = val;
    #1;
    if (stalled) begin
      check(dig_valid_o && {dig_neg_o, dig_nz_o, dig_last_o} == stall_snap,
            "R7", "held digit", {dig_valid_o, dig_neg_o, dig_nz_o, dig_last_o},
            {1'b1, stall_snap});
    end
    if (dig_valid_o) begin
      check(dig_skip_o == !dig_nz_o, "R8", "skip flag", dig_skip_o, !dig_nz_o);
    end
    if (dig_valid_o && rdy) begin
      d = dig_nz_o ? (dig_neg_o ? -1 : 1) : 0;
      if (exp_q.size() > 0) begin
        check(d == exp_q[0], "R4", "digit value", d, exp_q[0]);
        void'(exp_q.pop_front());
      end else check(1'b0, "R6", "extra digit", cnt, WIDTH);
      check(dig_last_o == (cnt == WIDTH), "R6", "last flag", dig_last_o, cnt == WIDTH);
      check(!(prev_d != 0 && d != 0), "R5", "adjacent non-zero", d, 0);
      sum += longint'(d) * (longint'(1) <<< cnt);
      prev_d = d;
      cnt++;
    end
    stalled = dig_valid_o && !rdy;
    stall_snap = {dig_neg_o, dig_nz_o, dig_last_o};
  endtask

  task automatic run_op(input logic [WIDTH-1:0] val, input bit do_load,
                        input bit irregular, input bit inject);
    int guard = 0;
    logic r;
    build_ref(longint'(val));
    cnt = 0; sum = 0; prev_d = 0;
    cyc(1'b1, do_load, 1'b1, val);
    cyc(1'b0, 1'b0, 1'b0, '0);
    check(busy_o && dig_valid_o && !done_o, "R3", "valid after start",
          {busy_o, dig_valid_o, done_o}, 3'b110);
    while (cnt <= WIDTH && guard < 2000) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      r = irregular ? lfsr[3] | lfsr[7] : 1'b1;
      if (inject && cnt == 5) cyc(r, 1'b1, 1'b1, ~val);
      else cyc(r, 1'b0, 1'b0, '0);
      guard++;
    end
    cyc(1'b0, 1'b0, 1'b0, '0);
    check(cnt == WIDTH + 1, "R6", "digit count", cnt, WIDTH + 1);
    check(done_o && !busy_o && !dig_valid_o, "R6", "done after last",
          {done_o, busy_o, dig_valid_o}, 3'b100);
    check(sum == longint'(val), "R4", "weighted sum", sum, longint'(val));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    stalled = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!dig_valid_o && !busy_o && !done_o, "R1", "reset state",
          {dig_valid_o, busy_o, done_o}, 0);
    @(negedge clk); rst_n = 1'b1;

    run_op(16'h0000, 1, 0, 0);
    run_op(16'hFFFF, 1, 0, 0);
    run_op(16'h5555, 1, 1, 0);
    run_op(16'hAAAA, 1, 1, 0);
    run_op(16'h0001, 1, 0, 0);
    run_op(16'h8000, 1, 1, 0);
    run_op(16'h7FFF, 1, 1, 0);
    run_op(16'hB6DB, 1, 1, 0);
    // R2/R3: load and start mid-run have no effect
    run_op(16'h3A5C, 1, 1, 1);
    // R2: start alone reuses the operand captured before the mid-run load
    run_op(16'h3A5C, 0, 0, 0);
    // R6: done stays high while idle, clears on load
    cyc(1'b1, 1'b0, 1'b0, '0);
    check(done_o, "R6", "done holds", done_o, 1);
    cyc(1'b1, 1'b1, 1'b0, 16'h1234);
    cyc(1'b1, 1'b0, 1'b0, '0);
    check(!done_o && !busy_o, "R6", "done cleared by load", done_o, 0);
    run_op(16'h1234, 0, 1, 0);
    for (int k = 0; k < 6; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      run_op(lfsr[15:0], 1, k[0], 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule